// File: doc/BRIEF.md
# Multi-Thread LUN Command Dispatcher

This block sits between several independent command threads and a single downstream flash sequencer that drives one chip enable shared by all LUNs of a NAND device. Each thread offers one operation at a time (read, program, erase or copyback) together with a flash row address. The block takes the LUN number from the upper part of the row address, above a bit boundary set by configuration, and keeps one pending slot per thread.

Every cycle the block issues at most one pending operation, chosen among those whose LUN is idle. A request that waits on a busy LUN does not block a later request to a free LUN, so operations on different LUNs overlap. Requests to the same LUN still leave in the order they arrived. A LUN becomes busy at the clock edge where its operation is issued. It becomes idle again when the sequencer reports completion for that LUN. A program can be held back while any read is outstanding, depending on a configuration bit.

Top module: `lun_dispatch`

## Requirements
- R1: After reset no thread holds a pending request, every `req_ready` bit is 1, `iss_valid` is 0, `req_err` is 0 and every LUN is idle.
- R2: The LUN number is the row address shifted right by `cfg_lun_lsb`. A value of `cfg_lun_lsb` of ROW_W or more (ROW_W = 24 by default) maps every row to LUN 0, so all requests serialize on one LUN.
- R3: A request whose decoded LUN number is NUM_LUNS or more is accepted and then discarded. It is never issued, and `req_err` for its thread is 1 for exactly the cycle after the acceptance edge.
- R4: `req_ready` for a thread is 1 exactly when that thread has no pending request. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1, and the pending request's row does not change until it is issued.
- R5: `iss_valid` is 1 in a cycle exactly when at least one pending request is eligible. A request is eligible when its LUN is idle, no earlier pending request targets the same LUN, and the program rule of R10 does not hold it. It is issued in that same cycle, and it may be issued no sooner than the cycle after its acceptance.
- R6: A LUN turns busy at the edge where a request to it is issued. It turns idle at the edge where `cmp_valid` is 1 with `cmp_lun` naming it. A completion for an idle LUN has no effect.
- R7: A request to an idle LUN is issued ahead of earlier requests that wait on busy LUNs. For example, arrivals C0→LUN0, C1→LUN0, C2→LUN1, C3→LUN0 issue as C0, C2, C1, C3.
- R8: Requests to the same LUN issue in arrival order, whatever their thread numbers. Among requests accepted at the same edge, the lower thread number counts as earlier.
- R9: When several requests are eligible in one cycle, the one with the lowest thread number is issued.
- R10: Opcodes are encoded read = 0, program = 1, erase = 2, copyback = 3. When `cfg_prog_after_read` is 0, a program is not eligible while any LUN has a read outstanding. When it is 1, this restriction is lifted. Erase, copyback and read are never held because of the operation type on other LUNs.
- R11: While `iss_valid` is 1, `iss_thread`, `iss_lun`, `iss_op` and `iss_row` give the thread number, decoded LUN, opcode and row address of the issued request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lun_lsb | input | SHIFT_W (5) | Row bit where the LUN field starts |
| cfg_prog_after_read | input | 1 | 1 lets a program issue while a read is outstanding |
| req_valid | input | NUM_THREADS (4) | Per-thread request valid |
| req_ready | output | NUM_THREADS (4) | Per-thread slot empty |
| req_op | input | 2*NUM_THREADS (8) | Per-thread opcode, thread t in bits [2t+1:2t] |
| req_row | input | ROW_W*NUM_THREADS (96) | Per-thread row address, thread t in bits [24t+23:24t] |
| req_err | output | NUM_THREADS (4) | One-cycle pulse: request rejected, LUN out of range |
| iss_valid | output | 1 | An operation is issued this cycle |
| iss_thread | output | TID_W (2) | Thread of the issued operation |
| iss_lun | output | LUN_W (2) | LUN of the issued operation |
| iss_op | output | 2 | Opcode of the issued operation |
| iss_row | output | ROW_W (24) | Row address of the issued operation |
| cmp_valid | input | 1 | Completion pulse from the sequencer |
| cmp_lun | input | LUN_W (2) | LUN that completed |

## Verification
A busy flag stuck at 1 shows up as a request that never leaves while its LUN is idle. A flag cleared too early shows up as a second issue to the same LUN before its completion pulse. Either one appears at `iss_valid` within one cycle of the event that should have changed it. A corrupted age relation shows up as same-LUN requests leaving in thread order rather than arrival order, and the out-of-order arrival scenario exposes it on the first release of the shared LUN. A wrong LUN decode changes `iss_lun` or `req_err` in the cycle after acceptance. The bench's reference model compares every output on every cycle, so each of these faults is reported at its first visible cycle.

// File: rtl/lun_dispatch_pkg.sv
package lun_dispatch_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_COPY  = 2'd3
    } nand_op_e;

    function automatic logic is_program(input nand_op_e op);
        return op == OP_PROG;
    endfunction

    function automatic logic is_read(input nand_op_e op);
        return op == OP_READ;
    endfunction

    // A program is held while reads are outstanding unless overlap is allowed
    function automatic logic prog_must_wait(input nand_op_e op,
                                            input logic allow_overlap,
                                            input logic any_read);
        return is_program(op) && !allow_overlap && any_read;
    endfunction

endpackage

// File: rtl/lun_req_slot.sv
module lun_req_slot
    import lun_dispatch_pkg::*;
#(
    parameter int ROW_W    = 24,
    parameter int NUM_LUNS = 4,
    parameter int LUN_W    = 2,
    parameter int SHIFT_W  = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  nand_op_e           in_op,
    input  logic [ROW_W-1:0]   in_row,
    input  logic [SHIFT_W-1:0] cfg_lsb,
    input  logic               take,
    output logic               ready,
    output logic               occ,
    output logic               cap,
    output nand_op_e           op,
    output logic [ROW_W-1:0]   row,
    output logic [LUN_W-1:0]   lun,
    output logic               err
);

    logic [ROW_W-1:0] field;
    logic             bad;
    logic             occ_q;
    logic             err_q;
    nand_op_e         op_q;
    logic [ROW_W-1:0] row_q;
    logic [LUN_W-1:0] lun_q;

    always_comb begin
        if (cfg_lsb >= SHIFT_W'(ROW_W)) begin
            field = '0;
        end else begin
            field = in_row >> cfg_lsb;
        end
        bad = field >= ROW_W'(NUM_LUNS);
    end

    assign ready = !occ_q;
    assign cap   = in_valid && !occ_q && !bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= 1'b0;
            err_q <= 1'b0;
            op_q  <= OP_READ;
            row_q <= '0;
            lun_q <= '0;
        end else begin
            err_q <= in_valid && !occ_q && bad;
            if (cap) begin
                occ_q <= 1'b1;
                op_q  <= in_op;
                row_q <= in_row;
                lun_q <= field[LUN_W-1:0];
            end else if (take) begin
                occ_q <= 1'b0;
            end
        end
    end

    assign occ = occ_q;
    assign op  = op_q;
    assign row = row_q;
    assign lun = lun_q;
    assign err = err_q;

    AST_REJECT_LEAVES_EMPTY: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !occ_q); // R3

    AST_PENDING_HELD: assert property (@(posedge clk) disable iff (rst)
        (occ_q && !take) |=> (occ_q && $stable(row_q))); // R4

    AST_TAKE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        take |-> occ_q); // R5

endmodule

// File: rtl/lun_age_matrix.sv
module lun_age_matrix #(
    parameter int NT = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NT-1:0]  cap,
    input  logic [NT-1:0]  occ,
    output logic [NT*NT-1:0] older
);

    // older_q[i][j] = 1 means slot i arrived before slot j
    logic older_q [NT][NT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NT; i++) begin
                for (int j = 0; j < NT; j++) begin
                    older_q[i][j] <= 1'b0;
                end
            end
        end else begin
            for (int i = 0; i < NT; i++) begin
                for (int j = 0; j < NT; j++) begin
                    if (i != j && (cap[i] || cap[j])) begin
                        if (cap[i] && cap[j]) begin
                            older_q[i][j] <= (i < j);
                        end else if (cap[j]) begin
                            older_q[i][j] <= occ[i];
                        end else begin
                            older_q[i][j] <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NT; i++) begin
            for (int j = 0; j < NT; j++) begin
                older[i*NT+j] = older_q[i][j];
            end
        end
    end

    for (genvar gi = 0; gi < NT; gi++) begin : g_row
        for (genvar gj = gi + 1; gj < NT; gj++) begin : g_col
            AST_AGE_ORDERED: assert property (@(posedge clk) disable iff (rst)
                (occ[gi] && occ[gj]) |-> (older_q[gi][gj] != older_q[gj][gi])); // R8
        end
    end

endmodule

// File: rtl/lun_busy_track.sv
module lun_busy_track #(
    parameter int NL    = 4,
    parameter int LUN_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_valid,
    input  logic [LUN_W-1:0] set_lun,
    input  logic             set_is_read,
    input  logic             clr_valid,
    input  logic [LUN_W-1:0] clr_lun,
    output logic [NL-1:0]    busy,
    output logic [NL-1:0]    rd_busy
);

    logic [NL-1:0] busy_q;
    logic [NL-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            rd_q   <= '0;
        end else begin
            for (int l = 0; l < NL; l++) begin
                if (set_valid && set_lun == LUN_W'(l)) begin
                    busy_q[l] <= 1'b1;
                    rd_q[l]   <= set_is_read;
                end else if (clr_valid && clr_lun == LUN_W'(l)) begin
                    busy_q[l] <= 1'b0;
                    rd_q[l]   <= 1'b0;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign rd_busy = rd_q;

    AST_ISSUE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        set_valid |-> !busy_q[set_lun]); // R5

    AST_BUSY_ON_ISSUE: assert property (@(posedge clk) disable iff (rst)
        set_valid |=> busy_q[$past(set_lun)]); // R6

    AST_IDLE_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (clr_valid && !(set_valid && set_lun == clr_lun)) |=> !busy_q[$past(clr_lun)]); // R6

    AST_READ_MARK_BUSY: assert property (@(posedge clk) disable iff (rst)
        (rd_q & ~busy_q) == '0); // R10

endmodule

// File: rtl/lun_issue_pick.sv
module lun_issue_pick #(
    parameter int NT    = 4,
    parameter int NL    = 4,
    parameter int LUN_W = 2,
    parameter int TID_W = 2
) (
    input  logic [NT-1:0]       occ,
    input  logic [NT*LUN_W-1:0] lun_flat,
    input  logic [NT-1:0]       wait_read,
    input  logic [NT*NT-1:0]    older,
    input  logic [NL-1:0]       busy,
    output logic [NT-1:0]       grant,
    output logic                any,
    output logic [TID_W-1:0]    idx
);

    logic [NT-1:0] elig;

    always_comb begin
        for (int i = 0; i < NT; i++) begin
            logic             blocked;
            logic [LUN_W-1:0] li;
            li      = lun_flat[i*LUN_W +: LUN_W];
            blocked = 1'b0;
            for (int j = 0; j < NT; j++) begin
                if (j != i && occ[j] && older[j*NT+i] &&
                    lun_flat[j*LUN_W +: LUN_W] == li) begin
                    blocked = 1'b1;
                end
            end
            elig[i] = occ[i] && !busy[li] && !blocked && !wait_read[i];
        end
    end

    always_comb begin
        grant = '0;
        any   = 1'b0;
        idx   = '0;
        for (int i = 0; i < NT; i++) begin
            if (elig[i] && !any) begin
                grant[i] = 1'b1;
                any      = 1'b1;
                idx      = TID_W'(i);
            end
        end
    end

endmodule

// File: rtl/lun_dispatch.sv
module lun_dispatch
    import lun_dispatch_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int NUM_LUNS    = 4,
    parameter int ROW_W       = 24,
    localparam int TID_W      = $clog2(NUM_THREADS),
    localparam int LUN_W      = $clog2(NUM_LUNS),
    localparam int SHIFT_W    = $clog2(ROW_W + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [SHIFT_W-1:0]           cfg_lun_lsb,
    input  logic                         cfg_prog_after_read,
    input  logic [NUM_THREADS-1:0]       req_valid,
    output logic [NUM_THREADS-1:0]       req_ready,
    input  logic [2*NUM_THREADS-1:0]     req_op,
    input  logic [ROW_W*NUM_THREADS-1:0] req_row,
    output logic [NUM_THREADS-1:0]       req_err,
    output logic                         iss_valid,
    output logic [TID_W-1:0]             iss_thread,
    output logic [LUN_W-1:0]             iss_lun,
    output logic [1:0]                   iss_op,
    output logic [ROW_W-1:0]             iss_row,
    input  logic                         cmp_valid,
    input  logic [LUN_W-1:0]             cmp_lun
);

    logic [NUM_THREADS-1:0]       s_occ;
    logic [NUM_THREADS-1:0]       s_cap;
    logic [NUM_THREADS-1:0]       s_wait;
    logic [NUM_THREADS*LUN_W-1:0] s_lun_flat;
    logic [LUN_W-1:0]             s_lun [NUM_THREADS];
    nand_op_e                     s_op  [NUM_THREADS];
    logic [ROW_W-1:0]             s_row [NUM_THREADS];
    logic [NUM_THREADS*NUM_THREADS-1:0] older;
    logic [NUM_LUNS-1:0]          busy;
    logic [NUM_LUNS-1:0]          rd_busy;
    logic [NUM_THREADS-1:0]       grant;
    logic                         pick_any;
    logic [TID_W-1:0]             pick_idx;
    logic                         any_read;

    assign any_read = |rd_busy;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
        lun_req_slot #(
            .ROW_W    (ROW_W),
            .NUM_LUNS (NUM_LUNS),
            .LUN_W    (LUN_W),
            .SHIFT_W  (SHIFT_W)
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .in_valid (req_valid[t]),
            .in_op    (nand_op_e'(req_op[2*t +: 2])),
            .in_row   (req_row[ROW_W*t +: ROW_W]),
            .cfg_lsb  (cfg_lun_lsb),
            .take     (grant[t]),
            .ready    (req_ready[t]),
            .occ      (s_occ[t]),
            .cap      (s_cap[t]),
            .op       (s_op[t]),
            .row      (s_row[t]),
            .lun      (s_lun[t]),
            .err      (req_err[t])
        );
        assign s_lun_flat[t*LUN_W +: LUN_W] = s_lun[t];
        assign s_wait[t] = prog_must_wait(s_op[t], cfg_prog_after_read, any_read);
    end

    lun_age_matrix #(
        .NT (NUM_THREADS)
    ) u_age (
        .clk   (clk),
        .rst   (rst),
        .cap   (s_cap),
        .occ   (s_occ),
        .older (older)
    );

    lun_issue_pick #(
        .NT    (NUM_THREADS),
        .NL    (NUM_LUNS),
        .LUN_W (LUN_W),
        .TID_W (TID_W)
    ) u_pick (
        .occ       (s_occ),
        .lun_flat  (s_lun_flat),
        .wait_read (s_wait),
        .older     (older),
        .busy      (busy),
        .grant     (grant),
        .any       (pick_any),
        .idx       (pick_idx)
    );

    assign iss_valid  = pick_any;
    assign iss_thread = pick_idx;
    assign iss_lun    = s_lun[pick_idx];
    assign iss_op     = s_op[pick_idx];
    assign iss_row    = s_row[pick_idx];

    lun_busy_track #(
        .NL    (NUM_LUNS),
        .LUN_W (LUN_W)
    ) u_busy (
        .clk         (clk),
        .rst         (rst),
        .set_valid   (pick_any),
        .set_lun     (s_lun[pick_idx]),
        .set_is_read (is_read(s_op[pick_idx])),
        .clr_valid   (cmp_valid),
        .clr_lun     (cmp_lun),
        .busy        (busy),
        .rd_busy     (rd_busy)
    );

    AST_PROG_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_op == 2'(OP_PROG) && !cfg_prog_after_read) |-> (rd_busy == '0)); // R10

    AST_ISSUE_WAS_PENDING: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> !req_ready[iss_thread]); // R5

endmodule

// File: tb/lun_dispatch_test.sv
module lun_dispatch_test;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int NL = 4;
    localparam int RW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    cfg_lun_lsb = 5'd24;
    logic          cfg_prog_after_read = 1'b0;
    logic [NT-1:0] req_valid = '0;
    logic [NT-1:0] req_ready;
    logic [2*NT-1:0]  req_op = '0;
    logic [RW*NT-1:0] req_row = '0;
    logic [NT-1:0] req_err;
    logic          iss_valid;
    logic [1:0]    iss_thread;
    logic [1:0]    iss_lun;
    logic [1:0]    iss_op;
    logic [RW-1:0] iss_row;
    logic          cmp_valid = 1'b0;
    logic [1:0]    cmp_lun = '0;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    int iss_log[$];

    // reference model state
    bit          m_pend [NT];
    int          m_stamp[NT];
    int          m_lun  [NT];
    int          m_op   [NT];
    logic [RW-1:0] m_row[NT];
    bit          m_busy [NL];
    bit          m_rd   [NL];
    bit          m_err  [NT];
    bit          m_rdy  [NT];
    int          stamp_ctr;
    int          eidx;
    bit          ok;
    bit          anyrd;
    logic [RW-1:0] fld;

    always #(CLK_PERIOD/2) clk = ~clk;

    lun_dispatch uut (
        .clk(clk), .rst(rst), .cfg_lun_lsb(cfg_lun_lsb),
        .cfg_prog_after_read(cfg_prog_after_read),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_row(req_row), .req_err(req_err), .iss_valid(iss_valid),
        .iss_thread(iss_thread), .iss_lun(iss_lun), .iss_op(iss_op),
        .iss_row(iss_row), .cmp_valid(cmp_valid), .cmp_lun(cmp_lun)
    );

    task automatic chk(input bit good, input string rq, input string what,
                       input longint act, input longint exp);
        compared++;
        if (!good) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", rq, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            for (int t = 0; t < NT; t++) begin
                m_pend[t] = 0; m_err[t] = 0; m_stamp[t] = 0;
            end
            for (int l = 0; l < NL; l++) begin
                m_busy[l] = 0; m_rd[l] = 0;
            end
            stamp_ctr = 0;
        end else if (!finished) begin
            anyrd = 0;
            for (int l = 0; l < NL; l++) anyrd = anyrd | m_rd[l];
            eidx = -1;
            for (int t = 0; t < NT; t++) begin
                if (m_pend[t] && !m_busy[m_lun[t]]) begin
                    ok = 1;
                    for (int s = 0; s < NT; s++)
                        if (s != t && m_pend[s] && m_lun[s] == m_lun[t] && m_stamp[s] < m_stamp[t])
                            ok = 0;
                    if (m_op[t] == 1 && !cfg_prog_after_read && anyrd) ok = 0;
                    if (ok && eidx < 0) eidx = t;
                end
            end
            // compare every output against the model
            chk(iss_valid == (eidx >= 0), "R5", "iss_valid", iss_valid, eidx >= 0);
            if (eidx >= 0 && iss_valid) begin
                chk(iss_thread == 2'(eidx), "R9", "iss_thread", iss_thread, eidx);
                chk(iss_lun == 2'(m_lun[eidx]), "R2", "iss_lun", iss_lun, m_lun[eidx]);
                chk(iss_op == 2'(m_op[eidx]), "R11", "iss_op", iss_op, m_op[eidx]);
                chk(iss_row == m_row[eidx], "R11", "iss_row", iss_row, m_row[eidx]);
            end
            for (int t = 0; t < NT; t++) begin
                chk(req_ready[t] == !m_pend[t], "R4", "req_ready", req_ready[t], !m_pend[t]);
                chk(req_err[t] == m_err[t], "R3", "req_err", req_err[t], m_err[t]);
            end
            if (iss_valid) iss_log.push_back(int'(iss_thread));
            // advance model to the next edge
            for (int t = 0; t < NT; t++) m_rdy[t] = !m_pend[t];
            if (cmp_valid) begin
                m_busy[cmp_lun] = 0; m_rd[cmp_lun] = 0;
            end
            if (eidx >= 0) begin
                m_busy[m_lun[eidx]] = 1;
                m_rd[m_lun[eidx]] = (m_op[eidx] == 0);
                m_pend[eidx] = 0;
            end
            for (int t = 0; t < NT; t++) begin
                m_err[t] = 0;
                if (req_valid[t] && m_rdy[t]) begin
                    fld = (cfg_lun_lsb >= 5'd24) ? '0 : (req_row[RW*t +: RW] >> cfg_lun_lsb);
                    if (fld >= RW'(NL)) begin
                        m_err[t] = 1;
                    end else begin
                        m_pend[t] = 1;
                        m_lun[t] = int'(fld);
                        m_op[t] = int'(req_op[2*t +: 2]);
                        m_row[t] = req_row[RW*t +: RW];
                        m_stamp[t] = stamp_ctr;
                        stamp_ctr++;
                    end
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        req_valid = '0;
        cmp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic put(input int t, input int op, input logic [RW-1:0] row);
        req_valid[t] = 1'b1;
        req_op[2*t +: 2] = 2'(op);
        req_row[RW*t +: RW] = row;
    endtask

    task automatic done(input int l);
        cmp_valid = 1'b1;
        cmp_lun = 2'(l);
        tick();
    endtask

    function automatic logic [RW-1:0] row22(input int l, input int low);
        return (RW'(l) << 22) | RW'(low);
    endfunction

    task automatic check_log(input string rq, input int n, input int e[4]);
        chk(iss_log.size() == n, rq, "issue count", iss_log.size(), n);
        for (int i = 0; i < n && i < iss_log.size(); i++)
            chk(iss_log[i] == e[i], rq, "issue order thread", iss_log[i], e[i]);
        iss_log.delete();
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: reset state
        chk(req_ready == 4'hF, "R1", "req_ready after reset", req_ready, 15);
        chk(iss_valid == 1'b0, "R1", "iss_valid after reset", iss_valid, 0);
        chk(req_err == 4'h0, "R1", "req_err after reset", req_err, 0);
        @(posedge clk); #1;
        iss_log.delete();

        // R2: default boundary maps everything to LUN 0, simultaneous arrivals (R8)
        put(1, 0, row22(3, 5));
        put(0, 2, row22(1, 7));
        tick();
        idle(4);
        done(0);
        idle(3);
        done(0);
        idle(2);
        check_log("R2", 2, '{0, 1, 0, 0});

        // R7 / R8: C0->L0 (t0), C1->L0 (t3), C2->L1 (t2), C3->L0 (t1)
        cfg_lun_lsb = 5'd22;
        put(0, 0, row22(0, 1)); tick();
        put(3, 0, row22(0, 2)); tick();
        put(2, 0, row22(1, 3)); tick();
        put(1, 0, row22(0, 4)); tick();
        idle(3);
        done(0); idle(2);
        done(0); idle(2);
        done(1); done(0);
        idle(2);
        check_log("R7", 4, '{0, 2, 3, 1});

        // R9: three eligible at once, lowest thread first
        put(3, 3, row22(3, 9));
        put(1, 2, row22(1, 9));
        put(2, 0, row22(2, 9));
        tick();
        idle(4);
        check_log("R9", 3, '{1, 2, 3, 0});
        done(1); done(2); done(3);
        idle(2);

        // R10: program held behind a read, erase not held
        cfg_prog_after_read = 1'b0;
        put(0, 0, row22(0, 11)); tick();
        put(1, 1, row22(1, 12)); tick();
        put(2, 2, row22(2, 13)); tick();
        idle(4);
        check_log("R10", 2, '{0, 2, 0, 0});
        done(0);
        idle(2);
        check_log("R10", 1, '{1, 0, 0, 0});
        done(1); done(2);
        cfg_prog_after_read = 1'b1;
        put(0, 0, row22(0, 14)); tick();
        put(1, 1, row22(1, 15)); tick();
        idle(3);
        check_log("R10", 2, '{0, 1, 0, 0});
        done(0); done(1);
        cfg_prog_after_read = 1'b0;
        idle(2);

        // R6: completion for an idle LUN is ignored
        put(0, 0, row22(0, 16)); tick();
        idle(2);
        put(1, 3, row22(0, 17)); tick();
        done(2);
        idle(3);
        check_log("R6", 1, '{0, 0, 0, 0});
        done(0);
        idle(2);
        check_log("R6", 1, '{1, 0, 0, 0});
        done(0);
        idle(2);

        // R3: out-of-range LUN rejected with one-cycle error
        cfg_lun_lsb = 5'd20;
        put(2, 0, RW'(24'h9_00001));
        tick();
        @(negedge clk); #1;
        chk(req_err[2] == 1'b1, "R3", "req_err after reject", req_err[2], 1);
        chk(req_ready[2] == 1'b1, "R3", "slot empty after reject", req_ready[2], 1);
        @(posedge clk); #1;
        @(negedge clk); #1;
        chk(req_err[2] == 1'b0, "R3", "req_err single cycle", req_err[2], 0);
        @(posedge clk); #1;
        idle(2);
        check_log("R3", 0, '{0, 0, 0, 0});
        put(2, 2, RW'(24'h3_00001));
        tick();
        idle(2);
        check_log("R2", 1, '{2, 0, 0, 0});
        done(3);
        idle(3);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule